// File: doc/BRIEF.md
# Two-Phase Interval Timer with Reset Watchdog

This peripheral holds two independent interval channels behind a small synchronous register bus. Each channel builds its period from two back-to-back down-count phases: a high phase, whose length comes from the channel's high-count register, then a low phase, whose length comes from its low-count register. The period in clock cycles is the sum of the two counts. Every completed period gives a one-cycle interrupt pulse. While the channel stays enabled it reloads and repeats, so the same channel can serve as a periodic tick or as a one-shot event source.

Channel 0 has a second use as a watchdog. If its high-count register is written with all ones in the low byte, the bits above bit 7 become the watchdog count. When that count runs out, a reset request is raised and held. Software reprograms a channel in three steps: clear its enable bit, write both counts, then set the enable bit again. Setting the enable bit restarts the count from the values just written.

Top module: `dual_phase_timer`

## Requirements
- R1: After a synchronous reset, all registers read zero and the interrupt, level and reset-request outputs are low.
- R2: The registers are mapped by byte address. Control is at 0x00, channel 1 high count at 0x04, channel 0 high count at 0x08, channel 1 low count at 0x0C and channel 0 low count at 0x10. Control bit 0 enables channel 0 and bit 1 enables channel 1, and only those two bits are stored. Every register reads back the value last written to it, and any other address reads zero.
- R3: The write edge that sets a channel's enable bit is cycle 0. The channel's first interrupt is seen during cycle 1+H+L, where H and L are the two counts, and it is high for exactly one cycle.
- R4: While the channel stays enabled, further interrupts follow every H+L cycles.
- R5: A count of 0 behaves as a count of 1.
- R6: A channel's level output is high during the H cycles of its high phase (cycles 1..H of each period) and low during its low phase. It is low while the channel is disabled.
- R7: A disabled channel gives no interrupt and holds its level output low. Enabling it again restarts the period from the current register values.
- R8: Channel 0 is in watchdog mode when bits 7:0 of its high-count register equal 0xFF. The count W is then bits 15:8 and up. The reset request rises in cycle 1+W after enabling, and it stays high, even after the channel is disabled, until the block is reset. In this mode channel 0 gives no interrupt.
- R9: If channel 0 is disabled before its watchdog count expires, no reset request is raised.
- R10: The two channels run independently. A disabled channel's interrupt stays low while the other channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | CNT_W | Write data |
| bus_we | input | 1 | Write strobe, one register write per cycle |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |
| irq_ch0 | output | 1 | Channel 0 end-of-period pulse |
| irq_ch1 | output | 1 | Channel 1 end-of-period pulse |
| tout_ch0 | output | 1 | Channel 0 phase level |
| tout_ch1 | output | 1 | Channel 1 phase level |
| rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench builds the block with CNT_W set to 16. With that width the counts stay small, and the watchdog field above bit 7 is still reachable with a short run. The bench sweeps every pair of high and low counts from 0 to 4 on both channels. For each pair it checks the interrupt and the level on every cycle against values worked out from the period arithmetic, including the phases that are clamped from zero. Watchdog counts 0 to 3, an abort before expiry, a disable in the middle of a period followed by a restart with new values, and the register map readback complete the run.

// File: rtl/dpt_pkg.sv
// Package: shared register offsets and the watchdog selection key.
// Assumes byte addressing with one register per 32-bit word slot.
package dpt_pkg;
    localparam int unsigned OFF_CTRL = 'h00;
    localparam int unsigned OFF_HI1  = 'h04;
    localparam int unsigned OFF_HI0  = 'h08;
    localparam int unsigned OFF_LO1  = 'h0C;
    localparam int unsigned OFF_LO0  = 'h10;
    localparam logic [7:0]  WDOG_KEY = 8'hFF;
    localparam int unsigned NUM_CH   = 2;
endpackage

// File: rtl/dpt_regs.sv
// Module: register file and read mux for the two-channel timer.
// Holds the enable bits and both count registers of each channel.
// Assumes one write per cycle. Reads are combinational.
module dpt_regs #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [CNT_W-1:0]                  wdata,
    input  logic                              we,
    output logic [CNT_W-1:0]                  rdata,
    output logic [dpt_pkg::NUM_CH-1:0]        en_q,
    output logic [dpt_pkg::NUM_CH-1:0][CNT_W-1:0] hi_q,
    output logic [dpt_pkg::NUM_CH-1:0][CNT_W-1:0] lo_q
);
    import dpt_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_HI1  = ADDR_W'(OFF_HI1);
    localparam logic [ADDR_W-1:0] A_HI0  = ADDR_W'(OFF_HI0);
    localparam logic [ADDR_W-1:0] A_LO1  = ADDR_W'(OFF_LO1);
    localparam logic [ADDR_W-1:0] A_LO0  = ADDR_W'(OFF_LO0);

    // Purpose: capture bus writes into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            hi_q <= '0;
            lo_q <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL:  en_q     <= wdata[NUM_CH-1:0];
                A_HI0:   hi_q[0]  <= wdata;
                A_HI1:   hi_q[1]  <= wdata;
                A_LO0:   lo_q[0]  <= wdata;
                A_LO1:   lo_q[1]  <= wdata;
                default: ;
            endcase
        end
    end

    // Purpose: return the stored value of the addressed register, zero elsewhere.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {{(CNT_W-NUM_CH){1'b0}}, en_q};
            A_HI0:   rdata = hi_q[0];
            A_HI1:   rdata = hi_q[1];
            A_LO0:   rdata = lo_q[0];
            A_LO1:   rdata = lo_q[1];
            default: rdata = '0;
        endcase
    end

    // R2: a control write lands in the enable bits on the next cycle
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_CTRL) |=> (en_q == $past(wdata[NUM_CH-1:0])));
endmodule

// File: rtl/dpt_channel.sv
// Module: one two-phase interval channel.
// Counts the high phase and then the low phase, pulses irq at the end of
// the period, and reloads. When WDOG is set and the high count's low byte
// holds the key, the channel acts as a watchdog instead and raises a sticky
// expired flag. Assumes CNT_W > 8. Counts are read live at every reload.
module dpt_channel #(
    parameter int CNT_W = 32,
    parameter bit WDOG  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] hi_val,
    input  logic [CNT_W-1:0] lo_val,
    output logic             irq,
    output logic             tout,
    output logic             expired
);
    import dpt_pkg::*;

    logic             running;
    logic             in_low;
    logic [CNT_W-1:0] cnt;
    logic             wd_mode;
    logic [CNT_W-1:0] hi_raw;
    logic [CNT_W-1:0] hi_eff;
    logic [CNT_W-1:0] lo_eff;

    // Purpose: choose the watchdog field or the plain count, then clamp zero to one.
    always_comb begin
        wd_mode = WDOG && (hi_val[7:0] == WDOG_KEY);
        hi_raw  = wd_mode ? {8'd0, hi_val[CNT_W-1:8]} : hi_val;
        hi_eff  = (hi_raw == '0) ? CNT_W'(1) : hi_raw;
        lo_eff  = (lo_val == '0) ? CNT_W'(1) : lo_val;
    end

    // Purpose: sequence the start, the two phases, reload and expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            in_low  <= 1'b0;
            cnt     <= '0;
            irq     <= 1'b0;
            expired <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (!en) begin
                running <= 1'b0;
                in_low  <= 1'b0;
            end else if (!running) begin
                running <= 1'b1;
                in_low  <= 1'b0;
                cnt     <= hi_eff;
            end else if (cnt > CNT_W'(1)) begin
                cnt <= cnt - CNT_W'(1);
            end else if (!in_low) begin
                if (wd_mode) begin
                    expired <= 1'b1;
                    cnt     <= hi_eff;
                end else begin
                    in_low <= 1'b1;
                    cnt    <= lo_eff;
                end
            end else begin
                in_low <= 1'b0;
                cnt    <= hi_eff;
                irq    <= 1'b1;
            end
        end
    end

    assign tout = running && !in_low;

    // R3: the interrupt lasts a single cycle
    a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R7: an interrupt only follows a cycle in which the channel was enabled
    a_r7_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en));
    // R8: expiry is sticky until reset
    a_r8_expired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired);
    // R9: expiry can only rise while enabled
    a_r9_expiry_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(en));
endmodule

// File: rtl/dual_phase_timer.sv
// Module: top of the two-channel timer. It joins the register file to one
// channel per enable bit. Channel 0 has the watchdog variant built in.
// Assumes a synchronous register bus with one write per cycle.
module dual_phase_timer #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_ch0,
    output logic              irq_ch1,
    output logic              tout_ch0,
    output logic              tout_ch1,
    output logic              rst_req
);
    import dpt_pkg::*;

    logic [NUM_CH-1:0]            en_q;
    logic [NUM_CH-1:0][CNT_W-1:0] hi_q;
    logic [NUM_CH-1:0][CNT_W-1:0] lo_q;
    logic [NUM_CH-1:0]            irq_v;
    logic [NUM_CH-1:0]            tout_v;
    logic [NUM_CH-1:0]            exp_v;

    dpt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .we    (bus_we),
        .rdata (bus_rdata),
        .en_q  (en_q),
        .hi_q  (hi_q),
        .lo_q  (lo_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dpt_channel #(.CNT_W(CNT_W), .WDOG(g == 0)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_q[g]),
            .hi_val  (hi_q[g]),
            .lo_val  (lo_q[g]),
            .irq     (irq_v[g]),
            .tout    (tout_v[g]),
            .expired (exp_v[g])
        );
    end

    assign irq_ch0  = irq_v[0];
    assign irq_ch1  = irq_v[1];
    assign tout_ch0 = tout_v[0];
    assign tout_ch1 = tout_v[1];
    assign rst_req  = exp_v[0];

    // R10: a disabled channel keeps its interrupt low
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[1] && !$past(en_q[1])) |-> !irq_ch1);
endmodule

// File: tb/dual_phase_timer_test.sv
module dual_phase_timer_test;
    localparam int TW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [TW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [TW-1:0] bus_rdata;
    logic          irq_ch0, irq_ch1, tout_ch0, tout_ch1, rst_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    dual_phase_timer #(.CNT_W(TW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_ch0(irq_ch0),
        .irq_ch1(irq_ch1), .tout_ch0(tout_ch0), .tout_ch1(tout_ch1),
        .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            finish_up();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = TW'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = AW'(a); bus_we = 1'b0;
        #1 d = int'(bus_rdata);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // R3 R4 R5 R6 R10: one enable run of channel ch, checked every cycle
    task automatic run_period(input int ch, input int h, input int l);
        int he = (h == 0) ? 1 : h;
        int le = (l == 0) ? 1 : l;
        int per = he + le;
        wr('h00, 0);
        wr(ch ? 'h04 : 'h08, h);
        wr(ch ? 'h0C : 'h10, l);
        wr('h00, 1 << ch);
        for (int k = 0; k <= 2 * per + 2; k++) begin
            bit ei, et, ai, at, ao;
            if (k > 0) @(negedge clk);
            ei = (k > 1) && ((k - 1) % per == 0);
            et = (k >= 1) && (((k - 1) % per) < he);
            ai = ch ? irq_ch1 : irq_ch0;
            at = ch ? tout_ch1 : tout_ch0;
            ao = ch ? irq_ch0 : irq_ch1;
            chk(ai == ei, (k <= per + 1) ? "R3/R5 irq timing" : "R4 irq repeat", ai, ei);
            chk(at == et, "R6/R5 level", at, et);
            chk(ao == 1'b0, "R10 other channel quiet", ao, 0);
        end
        wr('h00, 0);
    endtask

    // R8: watchdog expiry after 1+W cycles and no interrupt on channel 0
    task automatic run_wdog(input int w);
        int we_ = (w == 0) ? 1 : w;
        int v;
        wr('h00, 0);
        wr('h08, (w << 8) | 'hFF);
        wr('h10, 2);
        rd('h08, v);
        chk(v == ((w << 8) | 'hFF), "R2 watchdog count readback", v, (w << 8) | 'hFF);
        wr('h00, 1);
        for (int k = 0; k <= we_ + 3; k++) begin
            bit er;
            if (k > 0) @(negedge clk);
            er = (k >= 1 + we_);
            chk(rst_req == er, "R8 reset request timing", rst_req, er);
            chk(irq_ch0 == 1'b0, "R8 no interrupt in watchdog mode", irq_ch0, 0);
        end
        wr('h00, 0);
        repeat (5) @(negedge clk);
        chk(rst_req == 1'b1, "R8 request sticky after disable", rst_req, 1);
        do_reset();
        chk(rst_req == 1'b0, "R8 request cleared by block reset", rst_req, 0);
    endtask

    initial begin
        int v;
        do_reset();
        // R1: reset state
        chk({irq_ch0, irq_ch1, tout_ch0, tout_ch1, rst_req} == 5'b0, "R1 outputs low", 1, 0);
        for (int a = 0; a <= 'h10; a += 4) begin
            rd(a, v);
            chk(v == 0, "R1 register zero", v, 0);
        end

        // R2: map, readback, control width, unmapped reads
        wr('h04, 'h1111); wr('h08, 'h2222); wr('h0C, 'h3333); wr('h10, 'h4444);
        rd('h04, v); chk(v == 'h1111, "R2 ch1 high readback", v, 'h1111);
        rd('h08, v); chk(v == 'h2222, "R2 ch0 high readback", v, 'h2222);
        rd('h0C, v); chk(v == 'h3333, "R2 ch1 low readback", v, 'h3333);
        rd('h10, v); chk(v == 'h4444, 'h4444 == 'h4444 ? "R2 ch0 low readback" : "", v, 'h4444);
        wr('h00, 'hFFFE);
        rd('h00, v); chk(v == 2, "R2 control keeps two bits", v, 2);
        wr('h00, 0);
        rd('h00, v); chk(v == 0, "R2 control cleared", v, 0);
        rd('h14, v); chk(v == 0, "R2 unmapped 0x14", v, 0);
        rd('h02, v); chk(v == 0, "R2 unmapped 0x02", v, 0);

        // R3 R4 R5 R6 R10: sweep both channels over counts 0..4
        for (int ch = 0; ch < 2; ch++)
            for (int h = 0; h <= 4; h++)
                for (int l = 0; l <= 4; l++)
                    run_period(ch, h, l);

        // R7: disable mid-period, stay quiet, restart from new values
        wr('h04, 3); wr('h0C, 3); wr('h00, 2);
        repeat (3) @(negedge clk);
        wr('h00, 0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(irq_ch1 == 1'b0, "R7 no interrupt while disabled", irq_ch1, 0);
            chk(tout_ch1 == 1'b0, "R7 level low while disabled", tout_ch1, 0);
        end
        wr('h04, 2); wr('h0C, 1); wr('h00, 2);
        for (int k = 0; k <= 5; k++) begin
            bit ei;
            if (k > 0) @(negedge clk);
            ei = (k == 4);
            chk(irq_ch1 == ei, "R7 restart from fresh counts", irq_ch1, ei);
        end
        wr('h00, 0);

        // R8: watchdog sweep
        for (int w = 0; w <= 3; w++) run_wdog(w);

        // R9: abort before expiry
        wr('h08, (6 << 8) | 'hFF); wr('h00, 1);
        repeat (3) @(negedge clk);
        wr('h00, 0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(rst_req == 1'b0, "R9 aborted watchdog stays quiet", rst_req, 0);
        end

        finish_up();
    end
endmodule